// File: doc/BRIEF.md
# Local SRAM Address-Window Controller

This block decides, for every processor access, whether a small on-chip SRAM claims it. A programmable window register holds a valid flag, a base address aligned to 4 KB, a write-protect flag and five exclusion masks, one per access class. An access is claimed only when all of these hold: the register is valid, the upper twenty address bits match the base, and the mask for the access class is clear. A claimed read returns SRAM data. A claimed write stores its data unless the window is write-protected. A protected write raises an access error and leaves the array untouched.

The access classes are CPU/interrupt-acknowledge space, supervisor code, supervisor data, user code and user data. Software can mask every code class to keep the array idle during instruction fetches, or mask every data class to keep it idle on operand traffic. Either choice saves power, because the array chip-enable rises only on a claimed access. A cache or ROM result arrives in parallel as `alt_rdata`. In the response cycle, read data comes from the SRAM when the access was claimed and from that parallel source otherwise.

Requests are sampled on a clock edge and answered one cycle later. A write to the window register takes effect for requests sampled on the following edge.

Top module: `sram_window_ctrl`

## Requirements
- R1: After reset the window register reads 0x00000000, and no access asserts `sram_ce` or `rsp_hit`.
- R2: No access is claimed while window register bit 0 (valid) is 0, whatever its address or class.
- R3: An access is claimed only when `req_addr[31:12]` equals window register bits [31:12]. Addresses 0x...000 through 0x...FFC inside the window are claimed, and the neighbouring pages are not.
- R4: The class mask bit decides the claim: bit 5 for `req_cpu`=1, bit 4 for supervisor code, bit 3 for supervisor data, bit 2 for user code and bit 1 for user data. A set bit excludes the class. `req_super` selects supervisor and `req_code` selects code.
- R5: A claimed read gives `rsp_valid`=1, `rsp_hit`=1, `rsp_err`=0 and the stored word on `rsp_rdata`, all in the cycle after the request.
- R6: A claimed write with window bit 8 (write-protect) at 0 stores `req_wdata` at word `req_addr[11:2]`, and a later claimed read returns it.
- R7: A claimed write with bit 8 at 1 gives `rsp_hit`=1 and `rsp_err`=1 in the next cycle, does not assert `sram_ce`, and leaves the stored word unchanged.
- R8: In the response cycle, `rsp_rdata` equals `alt_rdata` unless the request was a claimed read, in which case the SRAM word replaces it.
- R9: `sram_ce` is asserted only in the cycle of a claimed access, and never for a masked, invalid, outside or protected-write request.
- R10: Window register bits 11:9 and 7:6 read as zero. A register write takes effect for requests sampled one edge later, and a request in the same cycle as the write still sees the old value.
- R11: The low attribute byte 0x2B claims only code classes, 0x35 claims only data classes, and 0x21 claims all four supervisor/user classes. CPU space is excluded under all three.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cr_we | input | 1 | Window register write strobe |
| cr_wdata | input | 32 | Window register write value |
| cr_rdata | output | 32 | Window register readback |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_super | input | 1 | 1 = supervisor, 0 = user |
| req_code | input | 1 | 1 = instruction fetch, 0 = data |
| req_cpu | input | 1 | CPU/interrupt-acknowledge space access |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data |
| alt_rdata | input | 32 | Parallel cache/ROM read result, response cycle |
| sram_ce | output | 1 | SRAM array enable, request cycle |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Access was claimed by the SRAM |
| rsp_err | output | 1 | Write-protect access error |
| rsp_rdata | output | 32 | Read data |

## Verification
A corrupted window register shows up at once. The readback port differs, and the next probe of each class gives the wrong `sram_ce` in the same cycle and the wrong `rsp_hit` one cycle later. A bad mask decode shows up on the first access of the affected class. The class table walks every class under each typical attribute byte, so such a fault shows up within a few cycles. A corrupted array or write-enable path stays hidden until the affected word is read back. For that reason, every write in the directed tests is followed by a read of the same word, and a protected write is followed by a read that must return the old value.

// File: rtl/sramw_pkg.sv
package sramw_pkg;
    localparam int ADDR_W    = 32;
    localparam int PAGE_BITS = 12;
    localparam int BASE_W    = ADDR_W - PAGE_BITS;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic              wprot;
        logic              mask_cpu;
        logic              mask_sc;
        logic              mask_sd;
        logic              mask_uc;
        logic              mask_ud;
        logic              valid;
    } win_cfg_t;

    typedef enum logic [2:0] {
        KIND_CPU = 3'd0,
        KIND_SC  = 3'd1,
        KIND_SD  = 3'd2,
        KIND_UC  = 3'd3,
        KIND_UD  = 3'd4
    } acc_kind_t;

    function automatic win_cfg_t cfg_from_word(input logic [ADDR_W-1:0] w);
        win_cfg_t c;
        c.base     = w[ADDR_W-1:PAGE_BITS];
        c.wprot    = w[8];
        c.mask_cpu = w[5];
        c.mask_sc  = w[4];
        c.mask_sd  = w[3];
        c.mask_uc  = w[2];
        c.mask_ud  = w[1];
        c.valid    = w[0];
        return c;
    endfunction

    function automatic logic [ADDR_W-1:0] cfg_to_word(input win_cfg_t c);
        logic [ADDR_W-1:0] w;
        w                      = '0;
        w[ADDR_W-1:PAGE_BITS]  = c.base;
        w[8]                   = c.wprot;
        w[5]                   = c.mask_cpu;
        w[4]                   = c.mask_sc;
        w[3]                   = c.mask_sd;
        w[2]                   = c.mask_uc;
        w[1]                   = c.mask_ud;
        w[0]                   = c.valid;
        return w;
    endfunction
endpackage

// File: rtl/sramw_basereg.sv
module sramw_basereg
    import sramw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cr_we,
    input  logic [ADDR_W-1:0] cr_wdata,
    output win_cfg_t          cfg,
    output logic [ADDR_W-1:0] cfg_word
);
    win_cfg_t cfg_d, cfg_q;

    logic unused_cr_bits;
    assign unused_cr_bits = ^{cr_wdata[11:9], cr_wdata[7:6]};

    always_comb begin
        cfg_d = cfg_q;
        if (cr_we) cfg_d = cfg_from_word(cr_wdata);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg      = cfg_q;
    assign cfg_word = cfg_to_word(cfg_q);

    // R10
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cr_we) |-> $stable(cfg_q));
endmodule

// File: rtl/sramw_match.sv
module sramw_match
    import sramw_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  win_cfg_t          cfg,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_super,
    input  logic              req_code,
    input  logic              req_cpu,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              claim,
    output logic              wr_store,
    output logic              wr_fault,
    output logic              rd_fetch,
    output logic [IDX_W-1:0]  word_idx
);
    localparam int LSB = PAGE_BITS - IDX_W;

    acc_kind_t kind;
    logic      masked;
    logic      page_eq;

    logic unused_low_addr;
    assign unused_low_addr = ^req_addr[LSB-1:0];

    always_comb begin
        if (req_cpu)        kind = KIND_CPU;
        else if (req_super) kind = req_code ? KIND_SC : KIND_SD;
        else                kind = req_code ? KIND_UC : KIND_UD;

        unique case (kind)
            KIND_CPU: masked = cfg.mask_cpu;
            KIND_SC:  masked = cfg.mask_sc;
            KIND_SD:  masked = cfg.mask_sd;
            KIND_UC:  masked = cfg.mask_uc;
            default:  masked = cfg.mask_ud;
        endcase

        page_eq  = (req_addr[ADDR_W-1:PAGE_BITS] == cfg.base);
        claim    = req_valid && cfg.valid && page_eq && !masked;
        wr_store = claim && req_write && !cfg.wprot;
        wr_fault = claim && req_write && cfg.wprot;
        rd_fetch = claim && !req_write;
        word_idx = req_addr[PAGE_BITS-1:LSB];
    end

    // R2
    valid_gate_chk: assert final (!claim || cfg.valid);
endmodule

// File: rtl/sramw_array.sv
module sramw_array #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 10
) (
    input  logic              clk,
    input  logic              ce,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (ce) begin
            if (we) mem[idx] <= wdata;
            else    rdata_q  <= mem[idx];
        end
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/sram_window_ctrl.sv
module sram_window_ctrl
    import sramw_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cr_we,
    input  logic [31:0]       cr_wdata,
    output logic [31:0]       cr_rdata,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_super,
    input  logic              req_code,
    input  logic              req_cpu,
    input  logic [31:0]       req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] alt_rdata,
    output logic              sram_ce,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata
);
    localparam int BYTE_LANES = DATA_W / 8;
    localparam int IDX_W      = PAGE_BITS - $clog2(BYTE_LANES);

    typedef struct packed {
        logic valid;
        logic hit;
        logic err;
        logic use_sram;
    } rsp_t;

    win_cfg_t          cfg;
    logic [ADDR_W-1:0] cfg_word;
    logic              claim, wr_store, wr_fault, rd_fetch;
    logic [IDX_W-1:0]  word_idx;
    logic [DATA_W-1:0] arr_rdata;
    rsp_t              rsp_d, rsp_q;

    sramw_basereg u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cr_we    (cr_we),
        .cr_wdata (cr_wdata),
        .cfg      (cfg),
        .cfg_word (cfg_word)
    );

    sramw_match #(.IDX_W(IDX_W)) u_match (
        .cfg       (cfg),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_super (req_super),
        .req_code  (req_code),
        .req_cpu   (req_cpu),
        .req_addr  (req_addr),
        .claim     (claim),
        .wr_store  (wr_store),
        .wr_fault  (wr_fault),
        .rd_fetch  (rd_fetch),
        .word_idx  (word_idx)
    );

    assign sram_ce = wr_store || rd_fetch;

    sramw_array #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_array (
        .clk   (clk),
        .ce    (sram_ce),
        .we    (wr_store),
        .idx   (word_idx),
        .wdata (req_wdata),
        .rdata (arr_rdata)
    );

    always_comb begin
        rsp_d          = '0;
        rsp_d.valid    = req_valid;
        rsp_d.hit      = claim;
        rsp_d.err      = wr_fault;
        rsp_d.use_sram = rd_fetch;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign cr_rdata  = cfg_word;
    assign rsp_valid = rsp_q.valid;
    assign rsp_hit   = rsp_q.hit;
    assign rsp_err   = rsp_q.err;
    assign rsp_rdata = rsp_q.use_sram ? arr_rdata : alt_rdata;

    // R9
    ce_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sram_ce |-> req_valid && cr_rdata[0]);
    // R3
    ce_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sram_ce |-> (req_addr[31:12] == cr_rdata[31:12]));
    // R5
    rsp_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    // R7
    err_is_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_hit && rsp_valid);
    // R7
    no_ce_on_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_write && cr_rdata[8]) |-> !sram_ce);
endmodule

// File: tb/tb_sram_window_ctrl.sv
`timescale 1ns/1ps
module tb_sram_window_ctrl;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        cr_we = 0;
    logic [31:0] cr_wdata = '0;
    logic [31:0] cr_rdata;
    logic        req_valid = 0, req_write = 0, req_super = 0, req_code = 0, req_cpu = 0;
    logic [31:0] req_addr = '0, req_wdata = '0, alt_rdata = '0;
    logic        sram_ce, rsp_valid, rsp_hit, rsp_err;
    logic [31:0] rsp_rdata;

    int checks = 0;
    int fails  = 0;

    logic        ce_s, v_s, hit_s, err_s;
    logic [31:0] rd_s;

    always #2 clk = ~clk;

    sram_window_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cr_we(cr_we), .cr_wdata(cr_wdata), .cr_rdata(cr_rdata),
        .req_valid(req_valid), .req_write(req_write), .req_super(req_super),
        .req_code(req_code), .req_cpu(req_cpu), .req_addr(req_addr),
        .req_wdata(req_wdata), .alt_rdata(alt_rdata), .sram_ce(sram_ce),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
    );

    // {attr[7:0], super, code, cpu, expected claim}
    localparam logic [11:0] CLASS_VEC [17] = '{
        {8'h2B, 4'b1101}, {8'h2B, 4'b1000}, {8'h2B, 4'b0101}, {8'h2B, 4'b0000}, {8'h2B, 4'b0010},
        {8'h35, 4'b1100}, {8'h35, 4'b1001}, {8'h35, 4'b0100}, {8'h35, 4'b0001}, {8'h35, 4'b0010},
        {8'h21, 4'b1101}, {8'h21, 4'b1001}, {8'h21, 4'b0101}, {8'h21, 4'b0001}, {8'h21, 4'b0010},
        {8'h01, 4'b0011}, {8'h2A, 4'b1100}
    };

    localparam logic [31:0] BASE = 32'h2000_0000;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cr_write(input logic [31:0] v);
        @(negedge clk);
        cr_we = 1; cr_wdata = v;
        @(negedge clk);
        cr_we = 0;
    endtask

    task automatic acc(input logic wr, input logic [31:0] a, input logic [31:0] wd,
                       input logic s, input logic c, input logic cpu, input logic [31:0] alt);
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = wd;
        req_super = s; req_code = c; req_cpu = cpu; alt_rdata = alt;
        #1 ce_s = sram_ce;
        @(negedge clk);
        req_valid = 0; req_write = 0;
        #1;
        v_s = rsp_valid; hit_s = rsp_hit; err_s = rsp_err; rd_s = rsp_rdata;
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        @(negedge clk);
        chk(cr_rdata == 32'h0, "R1 readback", cr_rdata, 32'h0);
        acc(0, 32'h0000_0010, 0, 1, 0, 0, 32'hAAAA_0001);
        chk(ce_s == 0, "R1 ce after reset", {31'd0, ce_s}, 32'd0);
        chk(hit_s == 0, "R1 hit after reset", {31'd0, hit_s}, 32'd0);
        // R8 miss passes parallel data
        chk(rd_s == 32'hAAAA_0001, "R8 miss alt data", rd_s, 32'hAAAA_0001);

        // R10 same-cycle write is not yet visible
        @(negedge clk);
        cr_we = 1; cr_wdata = BASE | 32'h21;
        req_valid = 1; req_addr = BASE; req_super = 1; req_code = 0; req_cpu = 0; req_write = 0;
        #1 ce_s = sram_ce;
        chk(ce_s == 0, "R10 old value in write cycle", {31'd0, ce_s}, 32'd0);
        @(negedge clk);
        cr_we = 0;
        #1 ce_s = sram_ce;
        chk(ce_s == 1, "R10 new value next cycle", {31'd0, ce_s}, 32'd1);
        req_valid = 0;

        // R10 reserved bits read zero
        cr_write(32'hFFFF_FFFF);
        chk(cr_rdata == 32'hFFFF_F13F, "R10 reserved bits", cr_rdata, 32'hFFFF_F13F);

        // R4 R11 class table
        for (int i = 0; i < 17; i++) begin
            logic [11:0] v;
            v = CLASS_VEC[i];
            cr_write(BASE | {24'd0, v[11:4]});
            acc(0, BASE | 32'h10, 0, v[3], v[2], v[1], 32'h5555_0000);
            chk(ce_s == v[0], $sformatf("R4 R11 ce row %0d", i), {31'd0, ce_s}, {31'd0, v[0]});
            chk(hit_s == v[0], $sformatf("R4 R11 hit row %0d", i), {31'd0, hit_s}, {31'd0, v[0]});
        end

        // R2 invalid window
        cr_write(BASE | 32'h20);
        acc(0, BASE | 32'h20, 0, 1, 1, 0, 32'h0);
        chk(ce_s == 0 && hit_s == 0, "R2 valid clear", {30'd0, ce_s, hit_s}, 32'd0);

        // R6 R5 write then read back
        cr_write(BASE | 32'h21);
        acc(1, BASE | 32'h40, 32'hCAFE_0040, 1, 0, 0, 32'h0);
        chk(ce_s == 1 && hit_s == 1 && err_s == 0, "R6 write claimed", {29'd0, ce_s, hit_s, err_s}, 32'd6);
        acc(1, BASE | 32'hFFC, 32'hBEEF_0FFC, 0, 0, 0, 32'h0);
        acc(0, BASE | 32'h40, 0, 0, 0, 0, 32'h1111_1111);
        chk(v_s == 1 && hit_s == 1 && err_s == 0, "R5 read response", {29'd0, v_s, hit_s, err_s}, 32'd6);
        chk(rd_s == 32'hCAFE_0040, "R6 R5 read data", rd_s, 32'hCAFE_0040);

        // R3 page boundary
        acc(0, BASE | 32'hFFC, 0, 1, 0, 0, 32'h2222_2222);
        chk(rd_s == 32'hBEEF_0FFC, "R3 top word of page", rd_s, 32'hBEEF_0FFC);
        acc(0, BASE + 32'h1000, 0, 1, 0, 0, 32'h3333_3333);
        chk(ce_s == 0 && hit_s == 0, "R3 next page", {30'd0, ce_s, hit_s}, 32'd0);
        chk(rd_s == 32'h3333_3333, "R8 outside alt data", rd_s, 32'h3333_3333);
        acc(0, BASE - 32'h4, 0, 1, 0, 0, 32'h0);
        chk(ce_s == 0 && hit_s == 0, "R3 previous page", {30'd0, ce_s, hit_s}, 32'd0);

        // R8 fetch hit overrides parallel result
        acc(0, BASE | 32'h40, 0, 1, 1, 0, 32'h4444_4444);
        chk(rd_s == 32'hCAFE_0040, "R8 fetch uses sram", rd_s, 32'hCAFE_0040);

        // R7 write protect
        cr_write(BASE | 32'h121);
        acc(1, BASE | 32'h40, 32'hDEAD_DEAD, 1, 0, 0, 32'h5555_5555);
        chk(ce_s == 0, "R7 R9 no ce on protected write", {31'd0, ce_s}, 32'd0);
        chk(hit_s == 1 && err_s == 1, "R7 error flag", {30'd0, hit_s, err_s}, 32'd3);
        chk(rd_s == 32'h5555_5555, "R8 write returns alt", rd_s, 32'h5555_5555);
        acc(0, BASE | 32'h40, 0, 1, 0, 0, 32'h0);
        chk(rd_s == 32'hCAFE_0040 && err_s == 0, "R7 memory unchanged", rd_s, 32'hCAFE_0040);

        // R9 idle cycle has no enable
        @(negedge clk);
        #1 chk(sram_ce == 0, "R9 idle", {31'd0, sram_ce}, 32'd0);

        // R1 reset clears valid again
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        acc(0, BASE | 32'h40, 0, 1, 0, 0, 32'h0);
        chk(cr_rdata == 0 && hit_s == 0, "R1 second reset", cr_rdata, 32'h0);

        summary();
        $finish;
    end
endmodule